// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a two-way set-associative cache placed between a processor request port and a word-wide main-memory port. The processor presents a 32-bit byte address, a read or write flag, a write word and per-byte enables, and holds them until the cache answers with a one-cycle ready pulse. The byte address is split into a tag, a set index and a byte offset within a 32-byte line. The set index picks one set. The stored tags of both ways in that set are compared in parallel.

A miss fetches the whole line from memory as a burst of eight single-word reads. The request is then looked up again and served from the cache. The write policy is chosen at run time by a mode input. Write-back mode allocates a line on a write miss and marks it dirty. A dirty line is copied back to memory before its way is refilled. Write-through mode writes every store to memory and never allocates a line on a write miss. The number of sets is a parameter. A full-size build uses 8192 sets, which gives a 14-bit tag and 512 KB of data. The default build is small so that it can be simulated.

The controller handles one request at a time. It holds ready low while it is moving data to or from memory.

Top module: `sa2_cache`

## Requirements
- R1: The byte offset is address bits [OFFSET_W-1:0], with the word inside the line at bits [OFFSET_W-1:2]. The set index is the next SET_W bits, which is the block number modulo the number of sets. The tag is the remaining upper bits. The defaults are OFFSET_W=5, which gives eight 32-bit words per line, and SET_W=4. Addresses 32 bytes apart fall in different sets. Addresses inside one line share that line.
- R2: A way hits only when its valid bit is 1 and its stored tag equals the address tag. Reset clears every valid bit, dirty bit and replacement bit, and it leaves req_ready and mem_req low. At most one way of a set hits at any time.
- R3: On a read miss the line is filled by eight memory reads at ascending word addresses, starting at the line base. The read is then answered from the cache. A later read anywhere in that line hits with no memory traffic and is answered one cycle after it is presented.
- R4: The refill way is the lowest-numbered invalid way of the set. When both ways are valid, the refill way is the least recently used way. Every hit and every fill makes the other way the next victim.
- R5: In write-back mode (wb_mode=1), a write hit changes only the bytes whose req_be bit is set (bit i covers data bits 8i+7:8i). It marks the line dirty, makes no memory access and completes in one cycle.
- R6: A dirty victim is written back with eight full-strobe (mem_wstrb=4'hF) writes at ascending word addresses of its own line, before the refill reads start. A clean victim causes no memory write.
- R7: In write-through mode (wb_mode=0), a write hit updates the cache line and also issues exactly one memory write to that word, with mem_wstrb equal to req_be.
- R8: A write miss in write-back mode first fills the line, then performs the write-hit action, with no memory write when the victim is clean. A write miss in write-through mode issues one strobed memory write, performs no read and leaves the cache unchanged.
- R9: req_ready is a single-cycle pulse for each request. It stays low while any memory access is in progress.
- R10: mem_req, mem_we, mem_addr and mem_wdata stay unchanged until the cycle in which mem_ack is seen. Any number of wait cycles before mem_ack is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1: write-back with write-allocate; 0: write-through without write-allocate |
| req_valid | input | 1 | Processor request present, held until req_ready |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with req_ready |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_wstrb | output | 4 | Memory write byte strobes |
| mem_ack | input | 1 | Memory accepted or completed the current word |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The bench places three and four lines in one set, so that the choice of victim is visible in which later reads still hit. A controller with a broken replacement bit would evict the line just used, and a hit would turn into an eight-read burst. It checks that evicting a clean line produces no memory writes, and that evicting a line dirtied earlier writes its merged bytes back at the old line's addresses before any refill read. A design that skipped the dirty check would either lose data or flood memory with writes. It checks write-through stores against memory contents and confirms that a write-through miss leaves the next read still missing. It also repeats a fill with memory wait cycles, which catches a controller that advances its burst counter without waiting for mem_ack.

// File: rtl/sa2_cache_pkg.sv
package sa2_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_MEMWR = 2'd3
    } cache_state_t;

endpackage

// File: rtl/sa2_tag_match.sv
module sa2_tag_match #(
    parameter int TAG_W = 23
) (
    input  logic [TAG_W-1:0]   want_tag,
    input  logic [2*TAG_W-1:0] way_tags,
    input  logic [1:0]         way_valid,
    output logic [1:0]         way_hit
);
    for (genvar w = 0; w < 2; w++) begin : g_way
        assign way_hit[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == want_tag);
    end
endmodule

// File: rtl/sa2_victim_pick.sv
module sa2_victim_pick (
    input  logic [1:0] way_valid,
    input  logic       lru_way,
    output logic       victim
);
    always_comb begin
        if (!way_valid[0])      victim = 1'b0;
        else if (!way_valid[1]) victim = 1'b1;
        else                    victim = lru_way;
    end
endmodule

// File: rtl/sa2_byte_merge.sv
module sa2_byte_merge #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] old_word,
    input  logic [8*BYTES-1:0] new_word,
    input  logic [BYTES-1:0]   byte_en,
    output logic [8*BYTES-1:0] merged
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = byte_en[b] ? new_word[8*b +: 8] : old_word[8*b +: 8];
    end
endmodule

// File: rtl/sa2_cache.sv
module sa2_cache #(
    parameter int ADDR_W   = 32,
    parameter int SET_W    = 4,
    parameter int OFFSET_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    import sa2_cache_pkg::*;

    localparam int SETS  = 1 << SET_W;
    localparam int CNT_W = OFFSET_W - 2;
    localparam int WPL   = 1 << CNT_W;
    localparam int TAG_W = ADDR_W - SET_W - OFFSET_W;

    typedef struct packed {
        cache_state_t      st;
        logic [CNT_W-1:0]  cnt;
        logic              way;
        logic              ready;
        logic [31:0]       rdata;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic [3:0]        be;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic [TAG_W-1:0] tag_q   [2][SETS];
    logic [31:0]      data_q  [2][SETS][WPL];
    logic [SETS-1:0]  valid_q [2];
    logic [SETS-1:0]  dirty_q [2];
    logic [SETS-1:0]  lru_q;

    // storage update controls, produced by the combinational process
    logic             dat_we_d, tag_we_d, dirty_we_d, lru_we_d;
    logic             dat_way_d, lru_val_d;
    logic [CNT_W-1:0] dat_idx_d;
    logic [31:0]      dat_val_d;

    logic [ADDR_W-1:0] cur_addr;
    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    logic [CNT_W-1:0]  cur_widx;
    logic [1:0]        set_valid, hit_vec;
    logic              victim, hit_way;
    logic [31:0]       hit_word, merged_word;

    assign cur_addr  = (ctl_q.st == ST_IDLE) ? req_addr : ctl_q.addr;
    assign cur_set   = cur_addr[OFFSET_W +: SET_W];
    assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
    assign cur_widx  = cur_addr[2 +: CNT_W];
    assign set_valid = {valid_q[1][cur_set], valid_q[0][cur_set]};
    assign hit_way   = hit_vec[1];
    assign hit_word  = data_q[hit_way][cur_set][cur_widx];

    sa2_tag_match #(.TAG_W(TAG_W)) u_match (
        .want_tag (cur_tag),
        .way_tags ({tag_q[1][cur_set], tag_q[0][cur_set]}),
        .way_valid(set_valid),
        .way_hit  (hit_vec)
    );

    sa2_victim_pick u_victim (
        .way_valid(set_valid),
        .lru_way  (lru_q[cur_set]),
        .victim   (victim)
    );

    sa2_byte_merge #(.BYTES(4)) u_merge (
        .old_word(hit_word),
        .new_word(req_wdata),
        .byte_en (req_be),
        .merged  (merged_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ready = 1'b0;
        dat_we_d   = 1'b0;
        tag_we_d   = 1'b0;
        dirty_we_d = 1'b0;
        lru_we_d   = 1'b0;
        dat_way_d  = hit_way;
        lru_val_d  = ~hit_way;
        dat_idx_d  = cur_widx;
        dat_val_d  = merged_word;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && !ctl_q.ready) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.be    = req_be;
                    ctl_d.cnt   = '0;
                    if (hit_vec != 2'b00) begin
                        lru_we_d = 1'b1;
                        if (!req_write) begin
                            ctl_d.rdata = hit_word;
                            ctl_d.ready = 1'b1;
                        end else begin
                            dat_we_d = 1'b1;
                            if (wb_mode) begin
                                dirty_we_d  = 1'b1;
                                ctl_d.ready = 1'b1;
                            end else begin
                                ctl_d.st = ST_MEMWR;
                            end
                        end
                    end else if (req_write && !wb_mode) begin
                        ctl_d.st = ST_MEMWR;
                    end else begin
                        ctl_d.way = victim;
                        ctl_d.st  = (set_valid[victim] && dirty_q[victim][cur_set])
                                    ? ST_WBACK : ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == CNT_W'(WPL-1)) ctl_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    dat_we_d  = 1'b1;
                    dat_way_d = ctl_q.way;
                    dat_idx_d = ctl_q.cnt;
                    dat_val_d = mem_rdata;
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == CNT_W'(WPL-1)) begin
                        tag_we_d  = 1'b1;
                        lru_we_d  = 1'b1;
                        lru_val_d = ~ctl_q.way;
                        ctl_d.st  = ST_IDLE;
                    end
                end
            end
            ST_MEMWR: begin
                if (mem_ack) begin
                    ctl_d.ready = 1'b1;
                    ctl_d.st    = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            valid_q[0] <= '0;
            valid_q[1] <= '0;
            dirty_q[0] <= '0;
            dirty_q[1] <= '0;
            lru_q      <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (lru_we_d) lru_q[cur_set] <= lru_val_d;
            if (dirty_we_d) dirty_q[hit_way][cur_set] <= 1'b1;
            if (tag_we_d) begin
                valid_q[ctl_q.way][cur_set] <= 1'b1;
                dirty_q[ctl_q.way][cur_set] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (dat_we_d) data_q[dat_way_d][cur_set][dat_idx_d] <= dat_val_d;
        if (tag_we_d) tag_q[ctl_q.way][cur_set] <= cur_tag;
    end

    assign req_ready = ctl_q.ready;
    assign rsp_rdata = ctl_q.rdata;

    always_comb begin
        mem_req   = (ctl_q.st != ST_IDLE);
        mem_we    = (ctl_q.st == ST_WBACK) || (ctl_q.st == ST_MEMWR);
        mem_addr  = {cur_tag, cur_set, ctl_q.cnt, 2'b00};
        mem_wdata = data_q[ctl_q.way][cur_set][ctl_q.cnt];
        mem_wstrb = 4'h0;
        case (ctl_q.st)
            ST_WBACK: begin
                mem_addr  = {tag_q[ctl_q.way][cur_set], cur_set, ctl_q.cnt, 2'b00};
                mem_wstrb = 4'hF;
            end
            ST_MEMWR: begin
                mem_addr  = {ctl_q.addr[ADDR_W-1:2], 2'b00};
                mem_wdata = ctl_q.wdata;
                mem_wstrb = ctl_q.be;
            end
            default: ;
        endcase
    end

    // R2: two ways of a set never hold the same valid tag
    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9: completion is a one-cycle pulse
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R9: processor is stalled while memory is busy
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R10: memory request held steady until acknowledged
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R6: a finished writeback burst is followed by refill reads
    assert_wback_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb == 4'hF && mem_ack && ctl_q.st == ST_WBACK
         && ctl_q.cnt == CNT_W'(WPL-1)) |=> (mem_req && !mem_we));

endmodule

// File: tb/sa2_cache_test.sv
module sa2_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0, n_fail = 0;
    int mem_delay = 0, wcnt = 0;
    int rd_n = 0, wr_n = 0, log_n = 0;
    logic [31:0] log_addr [256];
    logic [31:0] mem    [4096];
    logic [31:0] shadow [4096];

    always #4 clk = ~clk;

    sa2_cache uut (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory responder with programmable wait cycles
    always @(posedge clk) begin
        if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req) begin
            if (wcnt >= mem_delay) begin
                mem_ack <= 1'b1;
                wcnt <= 0;
                log_addr[log_n[7:0]] <= mem_addr;
                log_n <= log_n + 1;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_wstrb[b]) mem[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    wr_n <= wr_n + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[13:2]];
                    rd_n <= rd_n + 1;
                end
            end else wcnt <= wcnt + 1;
        end
    end

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        for (int b = 0; b < 4; b++) if (be[b]) o[8*b +: 8] = n[8*b +: 8];
        return o;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int cyc, rd0, wr0, lg0;
    logic [31:0] rd;
    bit pulse_ok;

    task automatic access(bit w, logic [31:0] a, logic [31:0] d, logic [3:0] be);
        rd0 = rd_n; wr0 = wr_n; lg0 = log_n;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!req_ready && cyc < 1000);
        rd = rsp_rdata;
        req_valid = 1'b0;
        @(negedge clk);
        pulse_ok = !req_ready;
        if (w) shadow[a[13:2]] = merge(shadow[a[13:2]], d, be);
    endtask

    localparam logic [31:0] A = 32'h100, B = 32'h300, C = 32'h500, D = 32'h700;
    localparam logic [31:0] E = 32'h140, F = 32'h180, G = 32'h1C0;

    task automatic t_reset();
        check(req_ready == 1'b0, "R2 reset ready", 32'(req_ready), 0);
        check(mem_req == 1'b0, "R2 reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_read_fill();
        access(0, A + 12, 0, 0);
        check(rd == shadow[(A + 12) >> 2], "R2 first access data", rd, shadow[(A + 12) >> 2]);
        check(rd_n - rd0 == 8, "R3 fill reads", rd_n - rd0, 8);
        check(wr_n - wr0 == 0, "R3 fill writes", wr_n - wr0, 0);
        for (int i = 0; i < 8; i++)
            check(log_addr[(lg0 + i) % 256] == A + 4 * i, "R3 burst order",
                  log_addr[(lg0 + i) % 256], A + 4 * i);
        check(pulse_ok, "R9 ready pulse", 0, 1);
        check(cyc > 8, "R9 stall during fill", cyc, 9);
        access(0, A + 28, 0, 0);
        check(cyc == 1 && rd_n == rd0, "R3 hit latency", cyc, 1);
        check(rd == shadow[(A + 28) >> 2], "R1 same-line data", rd, shadow[(A + 28) >> 2]);
        access(0, A + 32, 0, 0);
        check(rd_n - rd0 == 8, "R1 next block other set misses", rd_n - rd0, 8);
        check(rd == shadow[(A + 32) >> 2], "R1 next block data", rd, shadow[(A + 32) >> 2]);
    endtask

    task automatic t_wb_hit();
        logic [31:0] old;
        wb_mode = 1'b1;
        old = mem[(A + 4) >> 2];
        access(1, A + 4, 32'hDEADBEEF, 4'b0101);
        check(cyc == 1, "R5 write hit latency", cyc, 1);
        check(wr_n == wr0 && rd_n == rd0, "R5 no memory traffic", wr_n - wr0, 0);
        check(mem[(A + 4) >> 2] == old, "R5 memory untouched", mem[(A + 4) >> 2], old);
        access(0, A + 4, 0, 0);
        check(rd == merge(old, 32'hDEADBEEF, 4'b0101), "R5 byte merge", rd,
              merge(old, 32'hDEADBEEF, 4'b0101));
    endtask

    task automatic t_replace();
        access(0, B, 0, 0);
        check(rd_n - rd0 == 8 && wr_n == wr0, "R4 fill invalid way", rd_n - rd0, 8);
        access(0, A, 0, 0);
        check(cyc == 1, "R4 first line kept", cyc, 1);
        access(0, C, 0, 0);
        check(wr_n - wr0 == 0, "R6 clean victim no write", wr_n - wr0, 0);
        access(0, A + 4, 0, 0);
        check(cyc == 1 && rd == shadow[(A + 4) >> 2], "R4 recent line kept", rd, shadow[(A + 4) >> 2]);
        access(0, B + 8, 0, 0);
        check(rd_n - rd0 == 8 && wr_n == wr0, "R4 lru victim clean", wr_n - wr0, 0);
        check(rd == shadow[(B + 8) >> 2], "R4 refill data", rd, shadow[(B + 8) >> 2]);
        access(0, D, 0, 0);
        check(wr_n - wr0 == 8, "R6 dirty writeback count", wr_n - wr0, 8);
        for (int i = 0; i < 8; i++)
            check(log_addr[(lg0 + i) % 256] == A + 4 * i, "R6 writeback before fill",
                  log_addr[(lg0 + i) % 256], A + 4 * i);
        check(log_addr[(lg0 + 8) % 256] == D, "R6 fill after writeback", log_addr[(lg0 + 8) % 256], D);
        check(mem[(A + 4) >> 2] == shadow[(A + 4) >> 2], "R6 merged data in memory",
              mem[(A + 4) >> 2], shadow[(A + 4) >> 2]);
        access(0, A + 4, 0, 0);
        check(rd_n - rd0 == 8 && rd == shadow[(A + 4) >> 2], "R6 reload", rd, shadow[(A + 4) >> 2]);
    endtask

    task automatic t_wt();
        wb_mode = 1'b0;
        access(1, D + 8, 32'h12345678, 4'b1111);
        check(wr_n - wr0 == 1 && rd_n == rd0, "R7 one memory write", wr_n - wr0, 1);
        check(mem[(D + 8) >> 2] == 32'h12345678, "R7 memory updated", mem[(D + 8) >> 2], 32'h12345678);
        access(0, D + 8, 0, 0);
        check(cyc == 1 && rd == 32'h12345678, "R7 cache updated", rd, 32'h12345678);
        access(1, E, 32'hCAFEF00D, 4'b0010);
        check(wr_n - wr0 == 1 && rd_n == rd0, "R8 wt miss no allocate", rd_n - rd0, 0);
        check(mem[E >> 2] == shadow[E >> 2], "R8 wt miss strobed", mem[E >> 2], shadow[E >> 2]);
        access(0, E, 0, 0);
        check(rd_n - rd0 == 8 && rd == shadow[E >> 2], "R8 wt miss left cache", rd_n - rd0, 8);
    endtask

    task automatic t_wb_alloc();
        logic [31:0] old;
        wb_mode = 1'b1;
        old = mem[F >> 2];
        access(1, F, 32'hA1B2C3D4, 4'b1100);
        check(rd_n - rd0 == 8 && wr_n == wr0, "R8 wb miss allocates", rd_n - rd0, 8);
        check(mem[F >> 2] == old, "R8 wb miss memory untouched", mem[F >> 2], old);
        access(0, F, 0, 0);
        check(cyc == 1 && rd == merge(old, 32'hA1B2C3D4, 4'b1100), "R8 wb miss merged", rd,
              merge(old, 32'hA1B2C3D4, 4'b1100));
    endtask

    task automatic t_wait();
        mem_delay = 3;
        access(0, G + 20, 0, 0);
        check(rd_n - rd0 == 8 && rd == shadow[(G + 20) >> 2], "R10 wait-state fill", rd,
              shadow[(G + 20) >> 2]);
        access(0, G, 0, 0);
        check(cyc == 1 && rd == shadow[G >> 2], "R10 wait-state line intact", rd, shadow[G >> 2]);
        mem_delay = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read_fill();
        t_wb_hit();
        t_replace();
        t_wt();
        t_wb_alloc();
        t_wait();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule